// File: doc/BRIEF.md
# Shared Interrupt Aggregator for a Multi-Port Serial Card

This block sits between a host I/O bus and a bank of up to eight serial channels. It decodes a contiguous address window and raises one chip select per channel. It gathers the channels' interrupt requests into a readable pending register. It also drives one shared interrupt line toward a host that detects edges rather than levels.

Each channel owns eight byte addresses. The channels sit back to back from a 16-bit base address. A separate 16-bit status address returns the pending register.

The shared line stays high while any channel is pending. A host that takes edges can lose a request that arrives while the line is already high. To avoid this, any write to the status address pulls the line low for one clock and lets it rise again if work remains. The host interrupt routine does this write before it returns, and in this way gets a fresh edge.

A parameter selects four or eight channels. With four channels, the window shrinks to 32 bytes and the upper status bits are forced to zero.

Top module: `irq_share_hub`

## Requirements
- R1: For an address `a` with `base <= a < base + 8*NUM_PORTS` (computed without wrap past 0xFFFF), chip select bit `(a-base)/8` is high. The chip select bit for port 1 is bit 0. For every other address, all chip selects are low. The decode is combinational.
- R2: At most one chip select is high at any time.
- R3: While `hostRdEn` is high and `hostAddr` equals `statusAddr`, `hostRdData` bit n-1 shows the request of port n as sampled at the previous rising clock edge. At all other times `hostRdData` is zero.
- R4: With NUM_PORTS=4, status bits 7..4 read 0, and requests on inputs 7..4 have no effect on `irqOut`.
- R5: `irqOut` is high from the second rising edge after any enabled request is high. It stays high while any enabled request is held. It falls on the second edge after the last enabled request drops.
- R6: A one-cycle write to `statusAddr` while requests are pending drives `irqOut` low for exactly the clock that follows the write edge. `irqOut` is high again one clock later.
- R7: A write to `statusAddr` with nothing pending leaves `irqOut` low. The written data never changes the status value that is read back.
- R8: After reset, `irqOut` is 0 and the status register reads 0.
- R9: Reading the status register has no side effect: repeated reads return the same value, and `irqOut` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hostAddr | input | 16 | Host I/O address |
| hostWrData | input | 8 | Host write data (ignored by the status register) |
| hostRdEn | input | 1 | Host read strobe |
| hostWrEn | input | 1 | Host write strobe |
| baseAddr | input | 16 | First byte of the channel window |
| statusAddr | input | 16 | Address of the pending register |
| portIrq | input | 8 | Interrupt request per channel, bit 0 is port 1 |
| portSel | output | 8 | Chip select per channel |
| hostRdData | output | 8 | Status read data |
| irqOut | output | 1 | Shared interrupt line |

## Verification
The assertions assume that a host write strobe lasts one clock and that the status address lies outside the channel window. Under these conditions, a retrigger shows as a single low cycle and the decode never mixes a chip select with a status access.

The stimulus changes every input on the falling clock edge and holds each write strobe for exactly one cycle. It keeps the status address clear of every window under test. It sweeps all 256 request patterns and every address around two window placements, one of which runs up to the top of the address space.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int MAX_PORTS = 8;
  localparam int STATUS_W  = 8;

  typedef struct packed {
    logic statusRead;
    logic statusWrite;
  } hubStrobe_t;
endpackage

// File: rtl/irq_hub_ctrl.sv
module irq_hub_ctrl
  import irq_hub_pkg::*;
#(
  parameter int NUM_PORTS  = 8,
  parameter int ADDR_W     = 16,
  parameter int PORT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] statusAddr,
  input  logic              hostRdEn,
  input  logic              hostWrEn,
  output logic [MAX_PORTS-1:0] portSel,
  output hubStrobe_t        strobe
);
  localparam int SPAN    = NUM_PORTS * PORT_BYTES;
  localparam int SHIFT   = $clog2(PORT_BYTES);
  localparam int IDX_W   = ADDR_W - SHIFT;
  localparam logic [ADDR_W:0] SPAN_W = (ADDR_W+1)'(SPAN);

  logic [ADDR_W:0]  offset;
  logic             inWindow;
  logic [IDX_W-1:0] portIdx;
  logic             statusHit;

  // Offset in one extra bit so that a window at the top of the space never wraps.
  assign offset    = {1'b0, hostAddr} - {1'b0, baseAddr};
  assign inWindow  = !offset[ADDR_W] && (offset < SPAN_W);
  assign portIdx   = offset[ADDR_W-1:SHIFT];
  assign statusHit = (hostAddr == statusAddr);

  for (genvar g = 0; g < MAX_PORTS; g++) begin : g_sel
    if (g < NUM_PORTS) begin : g_live
      assign portSel[g] = inWindow && (portIdx == IDX_W'(g));
    end else begin : g_dead
      assign portSel[g] = 1'b0;
    end
  end

  assign strobe.statusRead  = hostRdEn && statusHit;
  assign strobe.statusWrite = hostWrEn && statusHit;

  // R2: chip selects are mutually exclusive
  a_r2_onehot_sel: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(portSel));
endmodule

// File: rtl/irq_hub_dp.sv
module irq_hub_dp
  import irq_hub_pkg::*;
#(
  parameter int NUM_PORTS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [MAX_PORTS-1:0] portIrq,
  input  hubStrobe_t          strobe,
  output logic [STATUS_W-1:0] rdData,
  output logic                irqOut
);
  logic [MAX_PORTS-1:0] liveMask;
  logic [MAX_PORTS-1:0] pendReg;
  logic                 anyPending;

  for (genvar g = 0; g < MAX_PORTS; g++) begin : g_mask
    assign liveMask[g] = (g < NUM_PORTS);
  end

  // One register stage captures requests; only live ports are kept.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pendReg <= '0;
    else        pendReg <= portIrq & liveMask;
  end

  assign anyPending = |pendReg;

  // A status write forces one low cycle; otherwise the line follows the pending set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irqOut <= 1'b0;
    else        irqOut <= anyPending && !strobe.statusWrite;
  end

  assign rdData = strobe.statusRead ? STATUS_W'(pendReg) : '0;

  // R5: a pending request with no retrigger keeps the line high
  a_r5_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (anyPending && !strobe.statusWrite) |=> irqOut);

  // R6: a status write always yields a low cycle next
  a_r6_retrigger_low: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.statusWrite |=> !irqOut);

  // R7: with nothing pending the line is low next cycle
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !anyPending |=> !irqOut);

  // R4: dead ports never show as pending
  a_r4_dead_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (pendReg & ~liveMask) == '0);
endmodule

// File: rtl/irq_share_hub.sv
module irq_share_hub
  import irq_hub_pkg::*;
#(
  parameter int NUM_PORTS  = 8,
  parameter int ADDR_W     = 16,
  parameter int PORT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostWrData,
  input  logic              hostRdEn,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] statusAddr,
  input  logic [7:0]        portIrq,
  output logic [7:0]        portSel,
  output logic [7:0]        hostRdData,
  output logic              irqOut
);
  hubStrobe_t strobe;
  logic       unusedWrData;

  // Write data never reaches the status register.
  assign unusedWrData = ^hostWrData;

  irq_hub_ctrl #(
    .NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .PORT_BYTES(PORT_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hostAddr(hostAddr), .baseAddr(baseAddr),
    .statusAddr(statusAddr), .hostRdEn(hostRdEn), .hostWrEn(hostWrEn),
    .portSel(portSel), .strobe(strobe)
  );

  irq_hub_dp #(.NUM_PORTS(NUM_PORTS)) u_dp (
    .clk(clk), .rst_n(rst_n), .portIrq(portIrq), .strobe(strobe),
    .rdData(hostRdData), .irqOut(irqOut)
  );
endmodule

// File: tb/irq_share_hub_test.sv
module irq_share_hub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [7:0]  hostWrData = '0;
  logic        hostRdEn = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [15:0] baseAddr = 16'h1230;
  logic [15:0] statusAddr = 16'h0400;
  logic [7:0]  portIrq = '0;
  logic [7:0]  portSel, selQuad, rdData, rdQuad;
  logic        irqOut, irqQuad;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irq_share_hub #(.NUM_PORTS(8)) uut (
    .clk(clk), .rst_n(rst_n), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdEn(hostRdEn), .hostWrEn(hostWrEn), .baseAddr(baseAddr),
    .statusAddr(statusAddr), .portIrq(portIrq), .portSel(portSel),
    .hostRdData(rdData), .irqOut(irqOut));

  irq_share_hub #(.NUM_PORTS(4)) uutQuad (
    .clk(clk), .rst_n(rst_n), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdEn(hostRdEn), .hostWrEn(hostWrEn), .baseAddr(baseAddr),
    .statusAddr(statusAddr), .portIrq(portIrq), .portSel(selQuad),
    .hostRdData(rdQuad), .irqOut(irqQuad));

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expSel(input logic [15:0] a, input logic [15:0] b, input int n);
    int off = int'(a) - int'(b);
    if (off >= 0 && off < 8*n) return 8'(1 << (off / 8));
    return 8'h00;
  endfunction

  task automatic readStatus(input logic [7:0] exp8, input logic [7:0] exp4, input string tag);
    hostAddr = statusAddr; hostRdEn = 1'b1;
    #1;
    chk(16'(rdData), 16'(exp8), tag);
    chk(16'(rdQuad), 16'(exp4), tag);
    hostRdEn = 1'b0;
  endtask

  task automatic writeStatus(input logic [7:0] d);
    @(negedge clk);
    hostAddr = statusAddr; hostWrData = d; hostWrEn = 1'b1;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic sweepDecode(input logic [15:0] b);
    baseAddr = b;
    for (int k = -16; k < 80; k++) begin
      hostAddr = 16'(int'(b) + k);
      #1;
      chk(16'(portSel), 16'(expSel(hostAddr, b, 8)), "R1 decode 8");
      chk(16'(selQuad), 16'(expSel(hostAddr, b, 4)), "R1 decode 4");
      chk(16'($countones(portSel) <= 1), 16'd1, "R2 onehot");
      chk(16'(rdData), 16'd0, "R3 no read data");
      #1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R8 reset state
    repeat (2) @(negedge clk);
    chk(16'(irqOut), 16'd0, "R8 irq reset");
    readStatus(8'h00, 8'h00, "R8 status reset");
    @(negedge clk); rst_n = 1'b1;

    // R1/R2 decode, including a window touching 0xFFFF
    @(negedge clk);
    sweepDecode(16'h1230);
    sweepDecode(16'hFFC0);
    baseAddr = 16'h1230;

    // R3/R4/R5 every request pattern
    for (int p = 0; p < 256; p++) begin
      @(negedge clk); portIrq = 8'(p);
      @(negedge clk);
      @(negedge clk);
      chk(16'(irqOut), 16'(|8'(p)), "R5 irq level 8");
      chk(16'(irqQuad), 16'(|(8'(p) & 8'h0F)), "R4 irq level 4");
      readStatus(8'(p), 8'(p) & 8'h0F, "R3 R4 status");
    end

    // R5 deassert after last request drops
    @(negedge clk); portIrq = 8'h80;
    @(negedge clk); @(negedge clk);
    chk(16'(irqOut), 16'd1, "R5 high");
    portIrq = 8'h00;
    @(negedge clk);
    chk(16'(irqOut), 16'd1, "R5 still high one edge");
    @(negedge clk);
    chk(16'(irqOut), 16'd0, "R5 low two edges");

    // R6 retrigger while pending
    portIrq = 8'h05;
    @(negedge clk); @(negedge clk);
    chk(16'(irqOut), 16'd1, "R6 pre");
    writeStatus(8'hFF);
    chk(16'(irqOut), 16'd0, "R6 low pulse");
    chk(16'(irqQuad), 16'd0, "R6 low pulse quad");
    @(negedge clk);
    chk(16'(irqOut), 16'd1, "R6 reassert");
    chk(16'(irqQuad), 16'd1, "R6 reassert quad");
    readStatus(8'h05, 8'h05, "R7 data ignored");

    // R9 reads have no side effect
    @(negedge clk);
    hostAddr = statusAddr; hostRdEn = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(16'(rdData), 16'h05, "R9 repeat read");
      chk(16'(irqOut), 16'd1, "R9 irq stable");
    end
    hostRdEn = 1'b0;

    // R7 write with nothing pending
    portIrq = 8'h00;
    @(negedge clk); @(negedge clk);
    writeStatus(8'hA5);
    chk(16'(irqOut), 16'd0, "R7 idle low");
    @(negedge clk);
    chk(16'(irqOut), 16'd0, "R7 idle low after");
    readStatus(8'h00, 8'h00, "R7 status unchanged");

    // R4 only dead ports requesting on the quad instance
    portIrq = 8'hF0;
    @(negedge clk); @(negedge clk);
    chk(16'(irqQuad), 16'd0, "R4 dead ports");
    chk(16'(irqOut), 16'd1, "R5 upper ports live");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule